// File: doc/BRIEF.md
# Byte-Programmed Single-Channel DMA Selector

This block is a one-channel DMA engine that sits on an 8-bit host bus. Software sets it up through a single I/O port. Each byte written to the port is shifted into a setup register. After four consecutive writes, the register holds a 20-bit memory address and an 8-bit mode byte, and the channel is ready for work. Any read of the port returns 0xFF and disarms the channel until four fresh writes have been made.

A peripheral starts a transfer with a one-cycle start pulse and a 16-bit byte count. The channel then moves bytes one at a time between memory and the peripheral. Memory is reached through a simple single-request master port. The peripheral side has one valid/ready byte stream for each direction.

The mode byte controls the transfer:
- direction of data movement,
- memory or I/O space,
- whether the address counts up or down,
- whether a wait cycle is added to each memory access.

Requests made while the channel is not armed, or while I/O space is selected, are refused with an error pulse. The stored address keeps its final value after a transfer, so the next transfer carries on from where the last one stopped.

Top module: `selch_top`

## Requirements
- R1: Each host write shifts the 28-bit setup register left by 8 and places the new byte in the low 8 bits. The high nibble of the oldest byte drops out. After writes b0,b1,b2,b3, `cfg_addr` = {b0[3:0],b1,b2} and `cfg_mode` = b3. Both outputs reflect the register after every write, one cycle after the write strobe.
- R2: `armed` is 1 only when exactly four writes have occurred since the last read or reset. Three writes, or five or more, leave it at 0.
- R3: A host read clears the write count, so `armed` is 0 from the next cycle. `host_rdata` is 0xFF in the cycle after the read strobe and 0x00 otherwise.
- R4: A start while not armed gives a one-cycle `xfer_err` pulse. It causes no memory request and no `xfer_done`.
- R5: Mode bit 6 set selects I/O space. A start in that mode gives `xfer_err` and no memory access.
- R6: Mode bit 7 clear moves data from memory to the peripheral. Each byte is read from memory and presented on `out_data` with `out_valid` asserted. The byte is held stable until `out_ready` is high.
- R7: Mode bit 7 set moves data from the peripheral to memory. Each byte is accepted on `in_data` when `in_valid` and `in_ready` are both high, and is then written to memory with `mem_we` high.
- R8: Each byte uses the current address. The address then steps by one: up when mode bit 5 is set, down when it is clear. It wraps modulo 2^20.
- R9: After a transfer of N bytes, `cfg_addr` has moved by N in the selected direction, and a following start continues from that address without reprogramming.
- R10: Mode bit 4 set holds each memory request for two cycles. Clear gives one cycle.
- R11: Mode bits 3:0 are a priority value. The value is visible on `cfg_mode` and does not change the accesses or data of a transfer.
- R12: `xfer_done` pulses for one cycle after the last byte completes. A zero length gives `xfer_done` with no access. A start while `xfer_busy` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe to the setup port |
| host_rd | input | 1 | Host read strobe of the setup port |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Read return, 0xFF after a read |
| armed | output | 1 | Exactly four writes since last read |
| cfg_addr | output | 20 | Current transfer address |
| cfg_mode | output | 8 | Current mode byte |
| xfer_start | input | 1 | Transfer request pulse |
| xfer_len | input | 16 | Byte count sampled with the start pulse |
| xfer_busy | output | 1 | Transfer in progress |
| xfer_done | output | 1 | One-cycle pulse at end of transfer |
| xfer_err | output | 1 | One-cycle pulse on a refused request |
| out_valid | output | 1 | Byte for peripheral valid |
| out_ready | input | 1 | Peripheral accepts the byte |
| out_data | output | 8 | Byte read from memory |
| in_valid | input | 1 | Peripheral byte valid |
| in_ready | output | 1 | Channel accepts a peripheral byte |
| in_data | input | 8 | Byte to write to memory |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 20 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid the cycle after a request |

## Verification
The assertions assume three things about the environment:
- Memory returns read data in the cycle after a request cycle, with no stall.
- The peripheral keeps `out_ready` and `in_valid` meaningful only in their own handshake.
- The host does not reprogram the channel while a transfer is running.

The stimulus keeps to these assumptions. Its memory model registers read data from a fixed function of the address on every request edge. Setup writes and port reads are issued only while the channel is idle. Peripheral-side handshake signals change only on the falling clock edge, and `out_ready` follows an irregular stall pattern.

// File: rtl/selch_pkg.sv
package selch_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 20;
    localparam int LEN_W  = 16;
    localparam int CNT_W  = 3;
    localparam int ARM_WRITES = 4;

    typedef struct packed {
        logic       to_mem;
        logic       io_space;
        logic       count_up;
        logic       wait_st;
        logic [3:0] prio;
    } mode_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_IN,
        ST_MEM,
        ST_RDAT,
        ST_OUT
    } xfer_state_e;

    function automatic logic [ADDR_W-1:0] next_addr(input logic [ADDR_W-1:0] a,
                                                    input logic up);
        return up ? a + ADDR_W'(1) : a - ADDR_W'(1);
    endfunction

endpackage

// File: rtl/selch_setup.sv
module selch_setup
    import selch_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W,
    parameter int CW = CNT_W,
    parameter int ARM_N = ARM_WRITES
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic          rd,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          armed,
    output logic          load,
    output logic [AW-1:0] load_addr,
    output logic [DW-1:0] mode
);
    localparam int SW = AW + DW;
    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

    logic [SW-1:0] sreg;
    logic [SW-1:0] sreg_next;
    logic [CW-1:0] cnt;

    assign sreg_next = {sreg[SW-DW-1:0], wdata};

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg  <= '0;
            cnt   <= '0;
            rdata <= '0;
        end else begin
            rdata <= rd ? {DW{1'b1}} : '0;
            if (wr) sreg <= sreg_next;
            if (rd)
                cnt <= '0;
            else if (wr && cnt != CNT_MAX)
                cnt <= cnt + CW'(1);
        end
    end

    assign armed     = (cnt == CW'(ARM_N));
    assign load      = wr;
    assign load_addr = sreg_next[SW-1:DW];
    assign mode      = sreg[DW-1:0];

    assert_rd_disarms_R3: assert property (@(posedge clk) disable iff (rst)
        rd |=> !armed);

    assert_rd_returns_ff_R3: assert property (@(posedge clk) disable iff (rst)
        rd |=> (rdata == {DW{1'b1}}));

endmodule

// File: rtl/selch_addr.sv
module selch_addr
    import selch_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          step,
    input  logic          up,
    output logic [AW-1:0] addr
);
    always_ff @(posedge clk) begin
        if (rst)
            addr <= '0;
        else if (load)
            addr <= load_val;
        else if (step)
            addr <= next_addr(addr, up);
    end
endmodule

// File: rtl/selch_xfer.sv
module selch_xfer
    import selch_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W,
    parameter int LW = LEN_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          armed,
    input  mode_t         mode,
    input  logic          start,
    input  logic [LW-1:0] len,
    input  logic [AW-1:0] addr,
    output logic          step,
    output logic          up,
    output logic          busy,
    output logic          done,
    output logic          err,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [DW-1:0] out_data,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [DW-1:0] in_data
);
    xfer_state_e   state;
    logic [LW-1:0] remaining;
    logic [DW-1:0] data_q;
    logic          ws_done;
    logic          lat_to_mem;
    logic          lat_up;
    logic          lat_wait;
    logic          mem_last;
    logic          last_byte;

    assign mem_last  = !(lat_wait && !ws_done);
    assign last_byte = (remaining == LW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            remaining  <= '0;
            data_q     <= '0;
            ws_done    <= 1'b0;
            done       <= 1'b0;
            err        <= 1'b0;
            lat_to_mem <= 1'b0;
            lat_up     <= 1'b0;
            lat_wait   <= 1'b0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        if (!armed || mode.io_space) begin
                            err <= 1'b1;
                        end else if (len == '0) begin
                            done <= 1'b1;
                        end else begin
                            remaining  <= len;
                            lat_to_mem <= mode.to_mem;
                            lat_up     <= mode.count_up;
                            lat_wait   <= mode.wait_st;
                            state      <= mode.to_mem ? ST_IN : ST_MEM;
                        end
                    end
                end
                ST_IN: begin
                    if (in_valid) begin
                        data_q <= in_data;
                        state  <= ST_MEM;
                    end
                end
                ST_MEM: begin
                    if (!mem_last) begin
                        ws_done <= 1'b1;
                    end else begin
                        ws_done <= 1'b0;
                        if (lat_to_mem) begin
                            remaining <= remaining - LW'(1);
                            if (last_byte) begin
                                state <= ST_IDLE;
                                done  <= 1'b1;
                            end else begin
                                state <= ST_IN;
                            end
                        end else begin
                            state <= ST_RDAT;
                        end
                    end
                end
                ST_RDAT: begin
                    data_q <= mem_rdata;
                    state  <= ST_OUT;
                end
                ST_OUT: begin
                    if (out_ready) begin
                        remaining <= remaining - LW'(1);
                        if (last_byte) begin
                            state <= ST_IDLE;
                            done  <= 1'b1;
                        end else begin
                            state <= ST_MEM;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        busy      = (state != ST_IDLE);
        mem_req   = (state == ST_MEM);
        mem_we    = (state == ST_MEM) && lat_to_mem;
        mem_addr  = addr;
        mem_wdata = data_q;
        step      = (state == ST_MEM) && mem_last;
        up        = lat_up;
        out_valid = (state == ST_OUT);
        out_data  = data_q;
        in_ready  = (state == ST_IN);
    end

    assert_err_no_access_R4: assert property (@(posedge clk) disable iff (rst)
        err |-> (!mem_req && !done));

    assert_out_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    assert_wait_two_cycles_R10: assert property (@(posedge clk) disable iff (rst)
        ($rose(mem_req) && lat_wait) |=> mem_req);

    assert_nowait_one_cycle_R10: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !lat_wait) |=> !mem_req);

    assert_done_idle_R12: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && !err));

endmodule

// File: rtl/selch_top.sv
module selch_top
    import selch_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W,
    parameter int LW = LEN_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          host_wr,
    input  logic          host_rd,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    output logic          armed,
    output logic [AW-1:0] cfg_addr,
    output logic [DW-1:0] cfg_mode,
    input  logic          xfer_start,
    input  logic [LW-1:0] xfer_len,
    output logic          xfer_busy,
    output logic          xfer_done,
    output logic          xfer_err,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [DW-1:0] out_data,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [DW-1:0] in_data,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata
);
    logic          load;
    logic [AW-1:0] load_addr;
    logic          step;
    logic          up;
    logic [DW-1:0] mode_raw;
    mode_t         mode;

    assign mode     = mode_t'(mode_raw);
    assign cfg_mode = mode_raw;

    selch_setup #(.DW(DW), .AW(AW)) u_setup (
        .clk(clk), .rst(rst), .wr(host_wr), .rd(host_rd), .wdata(host_wdata),
        .rdata(host_rdata), .armed(armed), .load(load), .load_addr(load_addr),
        .mode(mode_raw)
    );

    selch_addr #(.AW(AW)) u_addr (
        .clk(clk), .rst(rst), .load(load), .load_val(load_addr),
        .step(step), .up(up), .addr(cfg_addr)
    );

    selch_xfer #(.DW(DW), .AW(AW), .LW(LW)) u_xfer (
        .clk(clk), .rst(rst), .armed(armed), .mode(mode), .start(xfer_start),
        .len(xfer_len), .addr(cfg_addr), .step(step), .up(up), .busy(xfer_busy),
        .done(xfer_done), .err(xfer_err), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data)
    );

    assert_req_only_busy_R4: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> xfer_busy);

endmodule

// File: tb/selch_top_test.sv
`timescale 1ns/1ps
module selch_top_test;
    logic clk = 0;
    always #5 clk = ~clk;

    logic        rst = 1;
    logic        host_wr = 0, host_rd = 0;
    logic [7:0]  host_wdata = 0, host_rdata;
    logic        armed;
    logic [19:0] cfg_addr;
    logic [7:0]  cfg_mode;
    logic        xfer_start = 0;
    logic [15:0] xfer_len = 0;
    logic        xfer_busy, xfer_done, xfer_err;
    logic        out_valid, out_ready = 1;
    logic [7:0]  out_data;
    logic        in_valid = 0, in_ready;
    logic [7:0]  in_data = 0;
    logic        mem_req, mem_we;
    logic [19:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata = 0;

    selch_top uut (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .armed(armed),
        .cfg_addr(cfg_addr), .cfg_mode(cfg_mode), .xfer_start(xfer_start),
        .xfer_len(xfer_len), .xfer_busy(xfer_busy), .xfer_done(xfer_done),
        .xfer_err(xfer_err), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    typedef struct { bit we; logic [19:0] a; logic [7:0] d; } acc_t;
    acc_t       exp_acc[$];
    logic [7:0] exp_out[$];
    logic [7:0] src_q[$];

    int n_chk = 0, n_err = 0;
    int err_seen = 0, done_seen = 0, acc_seen = 0;
    int exp_req_len = 1, req_run = 0, cyc = 0;
    bit prev_req = 0, in_pend = 0, finished = 0;

    function automatic logic [7:0] memf(input logic [19:0] a);
        return a[7:0] ^ {a[11:8], a[19:16]} ^ 8'h5A;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) if (mem_req && !mem_we) mem_rdata <= memf(mem_addr);

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            cyc++;
            if (xfer_err)  err_seen++;
            if (xfer_done) done_seen++;
            if (mem_req) begin
                req_run++;
                if (!prev_req) begin
                    acc_seen++;
                    if (exp_acc.size() == 0) begin
                        check(0, "R4", "unexpected memory access", int'(mem_addr), 0);
                    end else begin
                        acc_t e;
                        e = exp_acc.pop_front();
                        check(mem_addr == e.a, "R8", "access address", int'(mem_addr), int'(e.a));
                        check(mem_we == e.we, "R7", "access write enable", int'(mem_we), int'(e.we));
                        if (e.we) check(mem_wdata == e.d, "R7", "write data", int'(mem_wdata), int'(e.d));
                    end
                end
            end else if (prev_req) begin
                check(req_run == exp_req_len, "R10", "request length", req_run, exp_req_len);
                req_run = 0;
            end
            prev_req = mem_req;

            out_ready = (cyc % 3) != 1;
            if (out_valid && out_ready) begin
                if (exp_out.size() == 0)
                    check(0, "R6", "unexpected output byte", int'(out_data), 0);
                else begin
                    logic [7:0] x;
                    x = exp_out.pop_front();
                    check(out_data == x, "R6", "output byte", int'(out_data), int'(x));
                end
            end

            if (in_pend || !in_valid) begin
                if (src_q.size() > 0) begin
                    in_data  = src_q.pop_front();
                    in_valid = 1;
                end else begin
                    in_valid = 0;
                end
            end
            in_pend = in_valid && in_ready;
        end
    end

    task automatic host_write(input logic [7:0] b);
        @(negedge clk); host_wr = 1; host_wdata = b;
        @(negedge clk); host_wr = 0;
    endtask

    task automatic host_read();
        @(negedge clk); host_rd = 1;
        @(negedge clk); host_rd = 0;
        check(host_rdata == 8'hFF, "R3", "read return", int'(host_rdata), 8'hFF);
        check(!armed, "R3", "armed after read", int'(armed), 0);
    endtask

    task automatic program_ch(input logic [19:0] a, input logic [7:0] m);
        host_read();
        host_write({4'h0, a[19:16]});
        host_write(a[15:8]);
        host_write(a[7:0]);
        host_write(m);
        check(armed, "R2", "armed after four writes", int'(armed), 1);
        check(cfg_addr == a, "R1", "address field", int'(cfg_addr), int'(a));
        check(cfg_mode == m, "R1", "mode field", int'(cfg_mode), int'(m));
    endtask

    task automatic pulse_start(input logic [15:0] n);
        @(negedge clk); xfer_start = 1; xfer_len = n;
        @(negedge clk); xfer_start = 0;
    endtask

    task automatic wait_end(input int d0, input int e0);
        int k;
        for (k = 0; k < 3000; k++) begin
            @(negedge clk);
            if (done_seen != d0 || err_seen != e0) break;
        end
        if (k == 3000) check(0, "R12", "transfer end timeout", 0, 1);
        repeat (4) @(negedge clk);
    endtask

    task automatic run_xfer(input bit wr, input logic [19:0] base, input int n,
                            input bit upd, input bit ws, input bit poke);
        int d0, e0, a0;
        logic [19:0] a;
        d0 = done_seen; e0 = err_seen; a0 = acc_seen;
        exp_req_len = ws ? 2 : 1;
        a = base;
        for (int i = 0; i < n; i++) begin
            acc_t e;
            e.we = wr; e.a = a; e.d = 8'hC0 + 8'(i);
            exp_acc.push_back(e);
            if (wr) src_q.push_back(e.d);
            else exp_out.push_back(memf(a));
            a = upd ? a + 20'd1 : a - 20'd1;
        end
        pulse_start(16'(n));
        if (poke) begin
            repeat (3) @(negedge clk);
            pulse_start(16'd1);
        end
        wait_end(d0, e0);
        check(done_seen == d0 + 1, "R12", "one done pulse", done_seen - d0, 1);
        check(err_seen == e0, "R12", "no error on transfer", err_seen - e0, 0);
        check(acc_seen == a0 + n, "R12", "access count", acc_seen - a0, n);
        check(exp_acc.size() == 0 && exp_out.size() == 0, "R6", "scoreboard drained",
              exp_acc.size() + exp_out.size(), 0);
        check(cfg_addr == a, "R9", "final address", int'(cfg_addr), int'(a));
    endtask

    task automatic expect_refuse(input string req);
        int d0, e0, a0;
        d0 = done_seen; e0 = err_seen; a0 = acc_seen;
        pulse_start(16'd3);
        wait_end(d0, e0);
        check(err_seen == e0 + 1, req, "error pulse", err_seen - e0, 1);
        check(done_seen == d0, req, "no done", done_seen - d0, 0);
        check(acc_seen == a0, req, "no access", acc_seen - a0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check(!armed && !xfer_busy && !mem_req && host_rdata == 8'h00, "R2",
              "reset state", int'({armed, xfer_busy, mem_req}), 0);

        // R1 R2: shift sequence and exact count
        host_read();
        host_write(8'h01); host_write(8'h23); host_write(8'h45);
        check(!armed, "R2", "armed after three writes", int'(armed), 0);
        host_write(8'h2A);
        check(armed, "R2", "armed after four writes", int'(armed), 1);
        check(cfg_addr == 20'h12345, "R1", "address after four", int'(cfg_addr), 20'h12345);
        check(cfg_mode == 8'h2A, "R1", "mode after four", int'(cfg_mode), 8'h2A);
        host_write(8'h77);
        check(!armed, "R2", "armed after five writes", int'(armed), 0);
        check(cfg_addr == 20'h3452A, "R1", "address after five", int'(cfg_addr), 20'h3452A);
        check(cfg_mode == 8'h77, "R1", "mode after five", int'(cfg_mode), 8'h77);

        // R4: refused while not armed
        host_read();
        expect_refuse("R4");

        // R5: I/O space refused
        program_ch(20'h00100, 8'h60);
        expect_refuse("R5");

        // R6 R8 R11: memory to peripheral, count up, priority 0xA
        program_ch(20'h12345, 8'h2A);
        check(cfg_mode[3:0] == 4'hA, "R11", "priority visible", int'(cfg_mode[3:0]), 4'hA);
        run_xfer(0, 20'h12345, 5, 1, 0, 0);

        // R9: continue from where it stopped
        run_xfer(0, 20'h1234A, 3, 1, 0, 0);

        // R7 R8 R10 R12: peripheral to memory, down with wrap, wait state, start while busy
        program_ch(20'h00002, 8'h90);
        run_xfer(1, 20'h00002, 4, 0, 1, 1);

        // R12: zero length
        begin
            int d0, a0;
            d0 = done_seen; a0 = acc_seen;
            pulse_start(16'd0);
            wait_end(d0, err_seen);
            check(done_seen == d0 + 1, "R12", "zero length done", done_seen - d0, 1);
            check(acc_seen == a0, "R12", "zero length no access", acc_seen - a0, 0);
            check(cfg_addr == 20'hFFFFE, "R12", "zero length address", int'(cfg_addr), 20'hFFFFE);
        end

        // R10 R8: read with wait state, wrap upward
        program_ch(20'hFFFFE, 8'h30);
        run_xfer(0, 20'hFFFFE, 3, 1, 1, 0);

        // R11: priority zero gives the same transfer
        program_ch(20'h12345, 8'h20);
        run_xfer(0, 20'h12345, 2, 1, 0, 0);

        repeat (10) @(negedge clk);
        check(exp_acc.size() == 0, "R12", "no stray access", exp_acc.size(), 0);
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_err++;
            $display("FAIL R12 watchdog: actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule